// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits between a receive MAC and the receive queue and decides, one frame at a time, whether a frame may enter the queue. Bytes arrive as a stream with start-of-frame, end-of-frame and CRC-error markers. The block compares the 6-byte destination address against a programmed station address and a 64-entry multicast hash table, under a set of enable inputs. It then re-emits the frame on its output, or suppresses it.

Every byte passes through a 6-stage delay line. The accept decision is ready when the sixth address byte arrives, which is the same cycle the first byte leaves the line, so a rejected frame emits no bytes at all. A CRC error is only known at the last byte, so it is reported through a commit flag on the output end-of-frame: 1 keeps the frame, 0 tells the queue to discard it. When stripping is selected, the four trailing CRC bytes are held back and never emitted.

The controller is a five-state machine:
- `S_STOPPED`: reception disabled.
- `S_IDLE`: enabled, waiting for a frame.
- `S_ADDR`: collecting the address.
- `S_PASS`: frame accepted.
- `S_SKIP`: frame rejected, or started while stopped.

Transitions:
- `S_STOPPED`→`S_IDLE` when the enable rises outside a frame.
- `S_IDLE`→`S_STOPPED` when the enable falls outside a frame.
- `S_STOPPED`/`S_IDLE`→`S_ADDR` on a start with the enable set.
- `S_STOPPED`/`S_IDLE`→`S_SKIP` on a start with the enable clear.
- `S_ADDR`→`S_PASS` or `S_SKIP` on the sixth byte.
- `S_ADDR`/`S_PASS`/`S_SKIP`→`S_IDLE` or `S_STOPPED` on the end byte, chosen by the enable at that moment.

Top module: `rx_frame_filter`

## Requirements
- R1: After reset, out_valid is 0. While rx_en is 0, a frame produces no output bytes.
- R2: With all_en set, a frame is accepted whatever its destination address.
- R3: With bcast_en set, a frame whose destination is all ones is accepted.
- R4: With mcast_en set, any frame whose group bit is 1 is accepted, broadcast included. The group bit is bit 0 of the first address byte.
- R5: With ucast_en set, a frame whose group bit is 0 is accepted only if its 48-bit destination equals station_addr. The first address byte is compared with station_addr[47:40], and so on down to the sixth byte with [7:0].
- R6: With hash_en set, a group-bit frame is accepted when hash_table[idx] is 1. idx is bits 31:26 of a CRC-32 over the six address bytes: reflected polynomial 0xEDB88320, register preset to all ones, bit 0 of each byte first, no final inversion.
- R7: On the output end-of-frame, out_commit is 0 if the frame carried in_crc_err and err_en was 0, and 1 otherwise.
- R8: With strip_en set, an accepted frame of N bytes is emitted as its first N-4 bytes, and out_eof marks byte N-4.
- R9: With strip_en clear, an accepted frame is emitted unchanged, and out_sof appears 6 clock edges after the first byte is sampled.
- R10: Clearing rx_en during a frame does not cut that frame short. Frames that begin while rx_en is 0 are dropped whole, even if rx_en rises during them.
- R11: All enable inputs except rx_en are sampled at start of frame; changes during a frame affect only later frames.
- R12: A frame that is not accepted emits no output bytes. Frames are at least 10 bytes long, and their bytes arrive on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | CRC error, meaningful with in_eof |
| rx_en | input | 1 | Receive enable |
| all_en | input | 1 | Accept every frame |
| bcast_en | input | 1 | Accept broadcast |
| mcast_en | input | 1 | Accept every group-address frame |
| ucast_en | input | 1 | Accept station-address match |
| hash_en | input | 1 | Accept group frames passing the hash |
| err_en | input | 1 | Keep frames with a CRC error |
| strip_en | input | 1 | Remove trailing 4 CRC bytes |
| station_addr | input | 48 | Station address |
| hash_table | input | 64 | Multicast hash bitmap |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First emitted byte of a frame |
| out_eof | output | 1 | Last emitted byte of a frame |
| out_commit | output | 1 | With out_eof: 1 keep, 0 discard |

## Verification
Each combination of the five address enables is crossed with five destination classes:
- broadcast;
- a group address whose hash bit is set;
- a group address whose hash bit is clear;
- the station address;
- a different individual address.

This separates each acceptance path from the others and shows that broadcast also falls under the multicast and hash rules. Every case is repeated with and without a CRC error under both error-keep settings, and with and without stripping, so commit polarity and emitted length are each checked against an independently computed frame. Directed frames toggle rx_en and other enables partway through a frame to show the frame-boundary sampling and the stop rule, and one frame measures the fixed latency.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [2:0] {
        S_STOPPED,
        S_IDLE,
        S_ADDR,
        S_PASS,
        S_SKIP
    } rxf_state_e;

    // Enables captured at start of frame
    typedef struct packed {
        logic all_en;
        logic bcast_en;
        logic mcast_en;
        logic ucast_en;
        logic hash_en;
        logic err_en;
        logic strip_en;
    } rxf_ctl_t;

    // One slot of the delay line
    typedef struct packed {
        logic       valid;
        logic       sof;
        logic       eof;
        logic       err;
        logic [7:0] data;
    } rxf_beat_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    // One byte of a reflected CRC-32 update, bit 0 first
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in, input logic [7:0] d);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_addr_track.sv
module rxf_addr_track
    import rxf_pkg::*;
#(
    parameter  int ADDR_BYTES = 6,
    parameter  int HASH_W     = 6,
    localparam int ADDR_W     = ADDR_BYTES * 8,
    localparam int HEAD_W     = ADDR_W - 8,
    localparam int TBL_N      = 1 << HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        byte_in,
    input  logic              take,
    input  logic              first,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [TBL_N-1:0]  hash_table,
    output logic              is_bcast,
    output logic              is_mcast,
    output logic              ucast_hit,
    output logic              hash_hit
);

    logic [HEAD_W-1:0] head_q;
    logic [31:0]       crc_q;
    logic [ADDR_W-1:0] full_da;
    logic [31:0]       crc_fin;
    logic [HASH_W-1:0] idx;

    // Leading address bytes and running hash CRC
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            crc_q  <= '1;
        end else if (take) begin
            head_q <= HEAD_W'({head_q, byte_in});
            crc_q  <= crc32_byte(first ? 32'hFFFF_FFFF : crc_q, byte_in);
        end
    end

    // Final address byte is combined straight from the input
    always_comb begin
        full_da   = {head_q, byte_in};
        crc_fin   = crc32_byte(crc_q, byte_in);
        idx       = crc_fin[31 -: HASH_W];
        hash_hit  = hash_table[idx];
        is_bcast  = &full_da;
        is_mcast  = full_da[ADDR_W-8];
        ucast_hit = (full_da == station_addr);
    end

endmodule

// File: rtl/rxf_ctrl_fsm.sv
module rxf_ctrl_fsm
    import rxf_pkg::*;
#(
    parameter  int ADDR_BYTES = 6,
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  logic     in_sof,
    input  logic     in_eof,
    input  logic     rx_en,
    input  rxf_ctl_t ctl_in,
    input  logic     is_bcast,
    input  logic     is_mcast,
    input  logic     ucast_hit,
    input  logic     hash_hit,
    output logic     addr_take,
    output logic     addr_first,
    output logic     acc_q,
    output logic     strip_q,
    output logic     keep_err_q
);

    localparam logic [CNT_W-1:0] LAST_DA = CNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(ADDR_BYTES);

    rxf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    rxf_ctl_t         snap_q;
    logic             at_gap, in_frame, frame_start, frame_end, last_da, hit_now;

    always_comb begin
        at_gap      = (state_q == S_STOPPED) || (state_q == S_IDLE);
        in_frame    = (state_q == S_ADDR) || (state_q == S_PASS) || (state_q == S_SKIP);
        frame_start = at_gap && in_valid && in_sof;
        frame_end   = in_frame && in_valid && in_eof;
        last_da     = in_frame && in_valid && (cnt_q == LAST_DA);
        addr_first  = frame_start;
        addr_take   = frame_start || ((state_q == S_ADDR) && in_valid && (cnt_q < LAST_DA));
        hit_now     = snap_q.all_en
                    | (is_bcast & snap_q.bcast_en)
                    | (is_mcast & snap_q.mcast_en)
                    | (~is_mcast & snap_q.ucast_en & ucast_hit)
                    | (is_mcast & snap_q.hash_en & hash_hit);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_STOPPED;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_STOPPED: begin
                if (frame_start) state_d = rx_en ? S_ADDR : S_SKIP;
                else if (rx_en)  state_d = S_IDLE;
            end
            S_IDLE: begin
                if (frame_start) state_d = rx_en ? S_ADDR : S_SKIP;
                else if (!rx_en) state_d = S_STOPPED;
            end
            S_ADDR: begin
                if (frame_end)    state_d = rx_en ? S_IDLE : S_STOPPED;
                else if (last_da) state_d = hit_now ? S_PASS : S_SKIP;
            end
            S_PASS, S_SKIP: begin
                if (frame_end) state_d = rx_en ? S_IDLE : S_STOPPED;
            end
            default: state_d = S_STOPPED;
        endcase
    end

    // Outputs: byte counter, snapshot and per-frame decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            snap_q     <= '0;
            acc_q      <= 1'b0;
            strip_q    <= 1'b0;
            keep_err_q <= 1'b0;
        end else begin
            if (frame_start) begin
                cnt_q  <= CNT_W'(1);
                snap_q <= ctl_in;
            end else if (in_frame && in_valid && (cnt_q < CNT_SAT)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (last_da) begin
                acc_q      <= (state_q == S_ADDR) && hit_now;
                strip_q    <= snap_q.strip_en;
                keep_err_q <= snap_q.err_en;
            end
        end
    end

    // R10: an accepted frame stays accepted until its own last byte
    a_r10_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PASS && !(in_valid && in_eof)) |=> (state_q == S_PASS));

    // R10: a stopped receiver never goes straight to forwarding
    a_r10_stopped_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOPPED) |=> (state_q != S_PASS));

    // R11: captured enables hold for the whole frame
    a_r11_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !frame_end) |=> $stable(snap_q));

endmodule

// File: rtl/rxf_delay_line.sv
module rxf_delay_line
    import rxf_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  rxf_beat_t             beat_in,
    output rxf_beat_t [DEPTH-1:0] line_o
);

    rxf_beat_t [DEPTH-1:0] line_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) line_q[g] <= '0;
                else        line_q[g] <= beat_in;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) line_q[g] <= '0;
                else        line_q[g] <= line_q[g-1];
            end
        end
    end

    assign line_o = line_q;

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
#(
    parameter  int ADDR_BYTES = 6,
    parameter  int CRC_BYTES  = 4,
    parameter  int HASH_W     = 6,
    localparam int ADDR_W     = ADDR_BYTES * 8,
    localparam int TBL_N      = 1 << HASH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              in_crc_err,
    input  logic              rx_en,
    input  logic              all_en,
    input  logic              bcast_en,
    input  logic              mcast_en,
    input  logic              ucast_en,
    input  logic              hash_en,
    input  logic              err_en,
    input  logic              strip_en,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic [TBL_N-1:0]  hash_table,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_commit
);

    localparam int DEPTH = ADDR_BYTES;
    localparam int TAIL  = DEPTH - 1;
    localparam int EARLY = DEPTH - 1 - CRC_BYTES;

    rxf_ctl_t              ctl;
    rxf_beat_t             beat_in;
    rxf_beat_t [DEPTH-1:0] line;
    logic                  addr_take, addr_first;
    logic                  is_bcast, is_mcast, ucast_hit, hash_hit;
    logic                  acc_q, strip_q, keep_err_q;
    logic [CRC_BYTES-1:0]  tail_crc_hit;
    logic                  in_crc_tail, eof_err, out_open_q;

    always_comb begin
        ctl     = '{all_en: all_en, bcast_en: bcast_en, mcast_en: mcast_en,
                    ucast_en: ucast_en, hash_en: hash_en, err_en: err_en,
                    strip_en: strip_en};
        beat_in = '{valid: in_valid, sof: in_valid & in_sof, eof: in_valid & in_eof,
                    err: in_valid & in_eof & in_crc_err, data: in_data};
    end

    rxf_addr_track #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .byte_in(in_data), .take(addr_take), .first(addr_first),
        .station_addr(station_addr), .hash_table(hash_table),
        .is_bcast(is_bcast), .is_mcast(is_mcast), .ucast_hit(ucast_hit), .hash_hit(hash_hit)
    );

    rxf_ctrl_fsm #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .rx_en(rx_en), .ctl_in(ctl), .is_bcast(is_bcast), .is_mcast(is_mcast),
        .ucast_hit(ucast_hit), .hash_hit(hash_hit), .addr_take(addr_take),
        .addr_first(addr_first), .acc_q(acc_q), .strip_q(strip_q), .keep_err_q(keep_err_q)
    );

    rxf_delay_line #(.DEPTH(DEPTH)) u_line (
        .clk(clk), .rst_n(rst_n), .beat_in(beat_in), .line_o(line)
    );

    // Tail byte lies in the trailing CRC when an end marker follows within the window
    for (genvar k = 0; k < CRC_BYTES; k++) begin : g_crc_look
        assign tail_crc_hit[k] = line[TAIL-k].valid & line[TAIL-k].eof;
    end

    always_comb begin
        in_crc_tail = |tail_crc_hit;
        out_valid   = line[TAIL].valid & acc_q & ~(strip_q & in_crc_tail);
        out_data    = out_valid ? line[TAIL].data : 8'h00;
        out_sof     = out_valid & line[TAIL].sof;
        out_eof     = out_valid & (strip_q ? line[EARLY].eof : line[TAIL].eof);
        eof_err     = strip_q ? line[EARLY].err : line[TAIL].err;
        out_commit  = out_eof & (~eof_err | keep_err_q);
    end

    // Output frame bracket tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    out_open_q <= 1'b0;
        else if (out_eof)              out_open_q <= 1'b0;
        else if (out_sof)              out_open_q <= 1'b1;
    end

    // R12: no frame starts on the output while another is still open
    a_r12_no_nested_sof: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> !out_open_q);

    // R12: every non-first output byte lies inside an opened frame
    a_r12_body_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> out_open_q);

endmodule

// File: tb/test_rx_frame_filter.sv
module test_rx_frame_filter;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_N    = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, in_sof = 0, in_eof = 0, in_crc_err = 0;
    logic [7:0]  in_data = 0;
    logic        rx_en = 0, all_en = 0, bcast_en = 0, mcast_en = 0, ucast_en = 0;
    logic        hash_en = 0, err_en = 0, strip_en = 0;
    logic [47:0] station_addr = 48'h02_12_34_56_78_9A;
    logic [63:0] hash_table = '0;
    logic        out_valid, out_sof, out_eof, out_commit;
    logic [7:0]  out_data;

    int checks = 0, failures = 0, cyc = 0;
    logic [7:0] got[$];
    int  n_sof, n_eof, sof_idx, eof_idx, sof_cyc, drive_cyc;
    logic got_commit;
    logic p_rx, p_all, p_strip, p_uc;

    rx_frame_filter i_rx_frame_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_crc_err(in_crc_err), .rx_en(rx_en), .all_en(all_en),
        .bcast_en(bcast_en), .mcast_en(mcast_en), .ucast_en(ucast_en), .hash_en(hash_en),
        .err_en(err_en), .strip_en(strip_en), .station_addr(station_addr),
        .hash_table(hash_table), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_commit(out_commit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor
    always @(negedge clk) begin
        if (out_valid) begin
            if (out_sof) begin n_sof++; sof_idx = got.size(); sof_cyc = cyc; end
            if (out_eof) begin n_eof++; eof_idx = got.size(); got_commit = out_commit; end
            got.push_back(out_data);
        end
    end

    function automatic logic [7:0] byte_of(logic [47:0] da, int i);
        return (i < 6) ? da[8*(5-i) +: 8] : 8'(8'h40 + i);
    endfunction

    function automatic logic [5:0] hash_idx(logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d = da[8*(5-i) +: 8];
            for (int b = 0; b < 8; b++) c = (c[0] ^ d[b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return c[31:26];
    endfunction

    function automatic bit exp_accept(logic [47:0] da);
        bit mc = da[40];
        return all_en | (&da & bcast_en) | (mc & mcast_en)
             | (!mc & ucast_en & (da == station_addr)) | (mc & hash_en & hash_table[hash_idx(da)]);
    endfunction

    task automatic clear_mon();
        got.delete(); n_sof = 0; n_eof = 0; sof_idx = -1; eof_idx = -1; got_commit = 0;
    endtask

    task automatic send_frame(logic [47:0] da, int n, bit err, int chg);
        clear_mon();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == chg) begin rx_en = p_rx; all_en = p_all; strip_en = p_strip; ucast_en = p_uc; end
            if (i == 0) drive_cyc = cyc;
            in_valid = 1; in_data = byte_of(da, i);
            in_sof = (i == 0); in_eof = (i == n - 1); in_crc_err = err && (i == n - 1);
        end
        @(negedge clk);
        in_valid = 0; in_sof = 0; in_eof = 0; in_crc_err = 0;
        repeat (10) @(negedge clk);
    endtask

    task automatic check_frame(string tag, bit acc, int n, bit strip, bit err, bit keep, logic [47:0] da);
        int  exp_n = acc ? (strip ? n - 4 : n) : 0;
        bit  ok = (got.size() == exp_n) && (n_sof == int'(acc)) && (n_eof == int'(acc));
        if (ok && acc) begin
            ok = (sof_idx == 0) && (eof_idx == exp_n - 1);
            foreach (got[i]) if (got[i] !== byte_of(da, i)) ok = 0;
        end
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s da=%h actual bytes=%0d sof=%0d eof=%0d expected bytes=%0d",
                     tag, strip ? "R8" : "R9", da, got.size(), n_sof, n_eof, exp_n);
        end
        if (acc) begin
            checks++;
            if (got_commit !== (!err || keep)) begin
                failures++;
                $display("FAIL R7 commit da=%h actual=%0b expected=%0b", da, got_commit, !err || keep);
            end
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [47:0] das[5];
        logic [63:0] tbls[5];
        p_rx = 0; p_all = 0; p_strip = 0; p_uc = 0;
        das[0] = 48'hFFFF_FFFF_FFFF;  das[1] = 48'h0100_5E00_0001;  das[2] = 48'h3333_0000_0001;
        das[3] = station_addr;        das[4] = station_addr ^ 48'h1;
        tbls[0] = 64'hA5A5_0F0F_5A5A_F0F0;
        tbls[1] = 64'd1 << hash_idx(das[1]);
        tbls[2] = ~(64'd1 << hash_idx(das[2]));
        tbls[3] = '1; tbls[4] = '1;

        // R1: reset state and disabled receiver
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin failures++; $display("FAIL R1 actual=%b expected=0", out_valid); end
        all_en = 1;
        send_frame(das[3], FRAME_N, 0, -1);
        check_frame("R1", 0, FRAME_N, 0, 0, 0, das[3]);

        // R9: fixed latency of first byte
        rx_en = 1;
        @(negedge clk);
        send_frame(das[4], FRAME_N, 0, -1);
        check_frame("R2", 1, FRAME_N, 0, 0, 0, das[4]);
        checks++;
        if (sof_cyc != drive_cyc + 6) begin
            failures++; $display("FAIL R9 latency actual=%0d expected=%0d", sof_cyc - drive_cyc, 6);
        end

        // Sweep: enables x address class x error x strip
        for (int m = 0; m < 32; m++)
            for (int t = 0; t < 5; t++)
                for (int e = 0; e < 4; e++)
                    for (int s = 0; s < 2; s++) begin
                        string tag;
                        bit acc;
                        {all_en, bcast_en, mcast_en, ucast_en, hash_en} = 5'(m);
                        err_en = e[1]; strip_en = s[0]; hash_table = tbls[t];
                        acc = exp_accept(das[t]);
                        if (all_en)      tag = "R2";
                        else if (t == 0) tag = "R3/R4";
                        else if (t < 3)  tag = mcast_en ? "R4" : "R6";
                        else             tag = "R5";
                        if (!acc) tag = {tag, "/R12"};
                        send_frame(das[t], FRAME_N, e[0], -1);
                        check_frame(tag, acc, FRAME_N, s[0], e[0], e[1], das[t]);
                    end

        // R10: clearing the enable mid-frame finishes the frame
        {all_en, bcast_en, mcast_en, ucast_en, hash_en, err_en, strip_en} = 7'b1000000;
        rx_en = 1; p_rx = 0; p_all = 1; p_strip = 0; p_uc = 0;
        send_frame(das[4], FRAME_N, 0, 3);
        check_frame("R10", 1, FRAME_N, 0, 0, 0, das[4]);
        send_frame(das[4], FRAME_N, 0, -1);
        check_frame("R10", 0, FRAME_N, 0, 0, 0, das[4]);
        p_rx = 1;
        send_frame(das[4], FRAME_N, 0, 2);
        check_frame("R10", 0, FRAME_N, 0, 0, 0, das[4]);
        send_frame(das[4], FRAME_N, 0, -1);
        check_frame("R10", 1, FRAME_N, 0, 0, 0, das[4]);

        // R11: mid-frame enable changes wait for the next frame
        p_rx = 1; p_all = 0; p_strip = 1; p_uc = 1;
        send_frame(das[4], FRAME_N, 0, 4);
        check_frame("R11", 1, FRAME_N, 0, 0, 0, das[4]);
        send_frame(das[4], FRAME_N, 0, -1);
        check_frame("R11", 0, FRAME_N, 1, 0, 0, das[4]);
        send_frame(das[3], FRAME_N, 0, -1);
        check_frame("R11", 1, FRAME_N, 1, 0, 0, das[3]);

        finish_run();
    end

endmodule